// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Clock

This block keeps the time of day and the day of the week in BCD and raises an alarm interrupt when the running time matches a programmed alarm time. A one-cycle tick pulse, one per second, advances the count while the run control allows it. The hours counter works in either a 24-hour or a 12-hour form; in the 12-hour form it carries an afternoon flag. Both forms are chosen by a bit inside the hours register.

Four alarm registers each carry an ignore bit. When a field's ignore bit is set, that field is left out of the comparison. By leaving out more fields, the alarm repeats every second, minute, hour, day or week. A match sets a sticky request flag. The interrupt output follows that flag while the interrupt enable is set. A host reaches every register through a flat read/write port. A read is combinational on the address, and a read strobe only marks the access. Any access to an alarm register clears the flag.

Top module: `clkAlm_top`

## Requirements
- R1: After reset, addresses 0 to 9 read 00,00,00,01,00,00,00,00,80,00 (hex), and irq is low. The clock is stopped and the interrupt is disabled.
- R2: Map: 0 seconds [6:0]; 1 minutes [6:0]; 2 hours [6:0]; 3 weekday [2:0]; 4 to 7 alarm seconds, minutes, hours and weekday, each with bit 7 as the ignore bit (alarm weekday keeps bits 7 and 2:0); 8 control (bit 7 stop, bit 0 interrupt enable); 9 status (bit 0 request flag, read-only). Bits that are not kept read 0. Addresses 10 and above read 0 and ignore writes.
- R3: While control bit 7 is 1, a tick changes nothing. While it is 0, each tick advances the time by one second, and the new value is readable in the cycle after the tick.
- R4: Seconds and minutes count in BCD from 00 to 59. On wrapping to 00 they carry into the next field.
- R5: With hours bit 6 = 0, hours count from 00 to 23 in BCD. Bits 5:4 hold the tens. The step 23 to 00 advances the weekday.
- R6: With hours bit 6 = 1, bit 5 is the afternoon flag and bits 4:0 count 12, 01 to 11. The step 11 to 12 toggles the flag. The step 11 to 12 with the flag set advances the weekday and clears the flag.
- R7: The weekday counts 1 to 7 and wraps to 1.
- R8: The tick that advances the time compares the new time with the alarm fields. A field with bit 7 = 1 is ignored. The hours comparison covers bits 6:0. If every field matches, the request flag (status bit 0) is set. Nothing sets the flag without an advancing tick.
- R9: irq is high exactly while the request flag is 1 and control bit 0 is 1.
- R10: A read strobe or a write to addresses 4 to 7 clears the flag. If it falls in the same cycle as a setting match, the flag stays set.
- R11: A host write to a time register (0 to 3) in a tick cycle stores the written value, and that tick is dropped for all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| hostAddr | input | ADDR_W | Register address |
| hostWr | input | 1 | Write strobe |
| hostRd | input | 1 | Read strobe (marks an access) |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data for hostAddr |
| irq | output | 1 | Active-high alarm interrupt |

## Verification
Two pairs of events can fall in the same clock cycle. The first is an alarm match that sets the flag together with a host access that clears it. The bench raises the tick and a read strobe on an alarm address at the same falling edge, and the flag must then still read 1. The second is a tick together with a host write to the seconds register. Here the written value must stand and the minutes must stay unchanged, and the next tick must count on from the written value.

// File: rtl/clkAlm_pkg.sv
package clkAlm_pkg;
  localparam int DW = 8;
  localparam int N_TIME = 4;
  localparam int N_ALM = 4;
  localparam int ADR_ALM0 = 4;
  localparam int ADR_CTL = 8;
  localparam int ADR_STAT = 9;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [2:0] day;
  } timeVec_t;

  typedef struct packed {
    logic advance;
    logic [N_TIME-1:0] wrTime;
    logic [N_ALM-1:0] wrAlm;
    logic wrCtl;
    logic almTouch;
  } strobe_t;

  function automatic logic [DW-1:0] almKeep(input int idx);
    return (idx == 3) ? 8'h87 : 8'hFF;
  endfunction

  function automatic logic [DW-1:0] bcdInc(input logic [DW-1:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction
endpackage

// File: rtl/clkAlm_ctrl.sv
module clkAlm_ctrl
  import clkAlm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DW-1:0]     hostWdata,
  input  logic              matchNext,
  output strobe_t           strb,
  output logic              oscStop,
  output logic              intEn,
  output logic              irqFlag,
  output logic              irq
);
  int addrI;

  always_comb begin
    addrI = int'(hostAddr);
    strb = '0;
    for (int k = 0; k < N_TIME; k++) strb.wrTime[k] = hostWr && (addrI == k);
    for (int k = 0; k < N_ALM; k++) strb.wrAlm[k] = hostWr && (addrI == ADR_ALM0 + k);
    strb.wrCtl = hostWr && (addrI == ADR_CTL);
    strb.almTouch = (hostWr || hostRd) && (addrI >= ADR_ALM0) && (addrI < ADR_ALM0 + N_ALM);
    strb.advance = tick && !oscStop && !(|strb.wrTime);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscStop <= 1'b1;
      intEn <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (strb.wrCtl) begin
        oscStop <= hostWdata[7];
        intEn <= hostWdata[0];
      end
      if (strb.advance && matchNext) irqFlag <= 1'b1;
      else if (strb.almTouch) irqFlag <= 1'b0;
    end
  end

  assign irq = irqFlag && intEn;
endmodule

// File: rtl/clkAlm_dp.sv
module clkAlm_dp
  import clkAlm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [DW-1:0] hostWdata,
  output timeVec_t      timeNow,
  output logic [DW-1:0] almReg [N_ALM],
  output logic          matchNext
);
  timeVec_t nxt;
  logic cMin, cHr, cDay;
  logic [DW-1:0] tmp;
  logic [DW-1:0] nxtField [N_ALM];
  logic [N_ALM-1:0] fieldOk;

  always_comb begin
    nxt = timeNow;
    cMin = 1'b0;
    cHr = 1'b0;
    cDay = 1'b0;
    tmp = '0;
    if (timeNow.sec == 7'h59) begin
      nxt.sec = '0;
      cMin = 1'b1;
    end else begin
      tmp = bcdInc({1'b0, timeNow.sec});
      nxt.sec = tmp[6:0];
    end
    if (cMin) begin
      if (timeNow.min == 7'h59) begin
        nxt.min = '0;
        cHr = 1'b1;
      end else begin
        tmp = bcdInc({1'b0, timeNow.min});
        nxt.min = tmp[6:0];
      end
    end
    if (cHr) begin
      if (timeNow.hour[6]) begin
        if (timeNow.hour[4:0] == 5'h12) begin
          nxt.hour[4:0] = 5'h01;
        end else if (timeNow.hour[4:0] == 5'h11) begin
          nxt.hour[4:0] = 5'h12;
          nxt.hour[5] = !timeNow.hour[5];
          cDay = timeNow.hour[5];
        end else begin
          tmp = bcdInc({3'b0, timeNow.hour[4:0]});
          nxt.hour[4:0] = tmp[4:0];
        end
      end else begin
        if (timeNow.hour[5:0] == 6'h23) begin
          nxt.hour = '0;
          cDay = 1'b1;
        end else begin
          tmp = bcdInc({2'b0, timeNow.hour[5:0]});
          nxt.hour = {1'b0, tmp[5:0]};
        end
      end
    end
    if (cDay) nxt.day = (timeNow.day >= 3'd7) ? 3'd1 : timeNow.day + 3'd1;
  end

  assign nxtField[0] = {1'b0, nxt.sec};
  assign nxtField[1] = {1'b0, nxt.min};
  assign nxtField[2] = {1'b0, nxt.hour};
  assign nxtField[3] = {5'b0, nxt.day};

  for (genvar k = 0; k < N_ALM; k++) begin : g_cmp
    assign fieldOk[k] = almReg[k][7] || (almReg[k][6:0] == nxtField[k][6:0]);
  end
  assign matchNext = &fieldOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeNow <= '{sec: '0, min: '0, hour: '0, day: 3'd1};
    end else if (|strb.wrTime) begin
      if (strb.wrTime[0]) timeNow.sec <= hostWdata[6:0];
      if (strb.wrTime[1]) timeNow.min <= hostWdata[6:0];
      if (strb.wrTime[2]) timeNow.hour <= hostWdata[6:0];
      if (strb.wrTime[3]) timeNow.day <= hostWdata[2:0];
    end else if (strb.advance) begin
      timeNow <= nxt;
    end
  end

  for (genvar k = 0; k < N_ALM; k++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rstN) almReg[k] <= '0;
      else if (strb.wrAlm[k]) almReg[k] <= hostWdata & almKeep(k);
    end
  end
endmodule

// File: rtl/clkAlm_top.sv
module clkAlm_top
  import clkAlm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              irq
);
  strobe_t strb;
  timeVec_t timeNow;
  logic [DW-1:0] almReg [N_ALM];
  logic matchNext, oscStop, intEn, irqFlag;

  clkAlm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .matchNext(matchNext), .strb(strb),
    .oscStop(oscStop), .intEn(intEn), .irqFlag(irqFlag), .irq(irq)
  );

  clkAlm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .timeNow(timeNow), .almReg(almReg), .matchNext(matchNext)
  );

  always_comb begin
    case (int'(hostAddr))
      0: hostRdata = {1'b0, timeNow.sec};
      1: hostRdata = {1'b0, timeNow.min};
      2: hostRdata = {1'b0, timeNow.hour};
      3: hostRdata = {5'b0, timeNow.day};
      4: hostRdata = almReg[0];
      5: hostRdata = almReg[1];
      6: hostRdata = almReg[2];
      7: hostRdata = almReg[3];
      ADR_CTL: hostRdata = {oscStop, 6'b0, intEn};
      ADR_STAT: hostRdata = {7'b0, irqFlag};
      default: hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/clkAlm_chk.sv
module clkAlm_chk
  import clkAlm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWr,
  input logic [7:0]        hostWdata,
  input logic              oscStop,
  input strobe_t           strb,
  input logic              matchNext,
  input logic              irqFlag,
  input timeVec_t          timeNow
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (oscStop && !hostWr) |=> (timeNow == $past(timeNow))); // R3
  AST_SEC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == '0) |=> (timeNow.sec == $past(hostWdata[6:0]))); // R11
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && matchNext) |=> irqFlag); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.almTouch && !(strb.advance && matchNext)) |=> !irqFlag); // R10
  AST_NO_IDLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !irqFlag) |=> !irqFlag); // R8
endmodule

bind clkAlm_top clkAlm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostWdata(hostWdata), .oscStop(oscStop), .strb(strb), .matchNext(matchNext),
  .irqFlag(irqFlag), .timeNow(timeNow)
);

// File: tb/tb_clkAlm_top.sv
module tb_clkAlm_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, hostWr = 1'b0, hostRd = 1'b0, irq;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWdata = '0, hostRdata;
  int total = 0, bad = 0;
  int ms, mm, mh, md;
  bit m12;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkAlm_top dut (.clk(clk), .rstN(rstN), .tick(tick), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input int v);
    @(negedge clk); hostAddr = 4'(a); hostWdata = 8'(v); hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic rdReg(input int a, output int v);
    hostAddr = 4'(a); #1; v = int'(hostRdata);
  endtask

  task automatic touch(input int a);
    @(negedge clk); hostAddr = 4'(a); hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic int bcd(input int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  function automatic int hourEnc();
    int h;
    if (!m12) return bcd(mh);
    h = mh % 12;
    if (h == 0) h = 12;
    return 'h40 | ((mh >= 12) ? 'h20 : 0) | bcd(h);
  endfunction

  task automatic modelTick();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin mh = 0; md = (md == 7) ? 1 : md + 1; end
  endtask

  task automatic setTime(input int d, input int h, input int m, input int s, input bit twelve);
    md = d; mh = h; mm = m; ms = s; m12 = twelve;
    wrReg(0, bcd(s)); wrReg(1, bcd(m)); wrReg(2, hourEnc()); wrReg(3, d);
  endtask

  task automatic checkTime(input string tag);
    int v;
    rdReg(0, v); chk({tag, " sec"}, v, bcd(ms));
    rdReg(1, v); chk({tag, " min"}, v, bcd(mm));
    rdReg(2, v); chk({tag, " hour"}, v, hourEnc());
    rdReg(3, v); chk({tag, " day"}, v, md);
  endtask

  task automatic setAlarm(input int s, input int m, input int h, input int d);
    wrReg(4, s); wrReg(5, m); wrReg(6, h); wrReg(7, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int exp1 [10] = '{0, 0, 0, 1, 0, 0, 0, 0, 'h80, 0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin rdReg(a, v); chk("R1 reset reg", v, exp1[a]); end
    chk("R1 irq", int'(irq), 0);
    // R3 stopped clock ignores ticks
    md = 1; mh = 0; mm = 0; ms = 0; m12 = 0;
    repeat (3) doTick();
    checkTime("R3 stopped");
    // R2 field masks
    wrReg(0, 'hFF); rdReg(0, v); chk("R2 sec keep", v, 'h7F);
    wrReg(3, 'hFF); rdReg(3, v); chk("R2 day keep", v, 'h07);
    wrReg(7, 'hFF); rdReg(7, v); chk("R2 almday keep", v, 'h87);
    wrReg(8, 'hFF); rdReg(8, v); chk("R2 ctl keep", v, 'h81);
    wrReg(12, 'hFF); rdReg(12, v); chk("R2 reserved", v, 0);
    wrReg(9, 'hFF); rdReg(9, v); chk("R2 status ro", v, 0);
    setAlarm(0, 0, 0, 0);
    wrReg(8, 'h00);
    // R3/R4 seconds sweep
    setTime(1, 0, 0, 0, 0);
    for (int i = 0; i < 61; i++) begin doTick(); modelTick(); checkTime("R4 sec sweep"); end
    // R4 minutes sweep
    for (int m = 0; m < 60; m++) begin
      setTime(1, 5, m, 59, 0); doTick(); modelTick(); checkTime("R4 min carry");
    end
    // R5 / R6 hours sweep both modes
    for (int t = 0; t < 2; t++)
      for (int h = 0; h < 24; h++) begin
        setTime(3, h, 59, 59, bit'(t)); doTick(); modelTick();
        checkTime(t ? "R6 12h step" : "R5 24h step");
      end
    // R7 weekday wrap
    for (int d = 1; d < 8; d++) begin
      setTime(d, 23, 59, 59, 0); doTick(); modelTick(); checkTime("R7 day step");
    end
    // R8 seconds alarm sweep
    setAlarm(0, 'h80, 'h80, 'h80);
    for (int t = 0; t < 60; t++) begin
      wrReg(4, bcd(t));
      setTime(2, 1, 10, (t + 59) % 60, 0);
      touch(4);
      rdReg(9, v); chk("R10 clear on read", v, 0);
      doTick(); rdReg(9, v); chk("R8 sec match", v, 1);
      touch(5); doTick(); rdReg(9, v); chk("R8 once per match", v, 0);
    end
    // R8 weekly match
    setAlarm('h30, 'h20, 'h10, 'h02);
    setTime(2, 10, 20, 29, 0); touch(4); doTick(); rdReg(9, v); chk("R8 weekly hit", v, 1);
    setTime(3, 10, 20, 29, 0); touch(4); doTick(); rdReg(9, v); chk("R8 weekly miss", v, 0);
    wrReg(7, 'h82);
    setTime(3, 10, 20, 29, 0); touch(4); doTick(); rdReg(9, v); chk("R8 daily hit", v, 1);
    // R8 12h alarm at 1 PM
    setAlarm('h00, 'h00, 'h61, 'h80);
    setTime(4, 12, 59, 59, 1); touch(4); doTick(); rdReg(9, v); chk("R8 pm hit", v, 1);
    setTime(4, 0, 59, 59, 1); touch(4); doTick(); rdReg(9, v); chk("R8 am miss", v, 0);
    // R9 interrupt gating
    setAlarm('h80, 'h80, 'h80, 'h80);
    doTick(); rdReg(9, v); chk("R8 every second", v, 1);
    chk("R9 irq disabled", int'(irq), 0);
    wrReg(8, 'h01); #1; chk("R9 irq enabled", int'(irq), 1);
    // R10 non-alarm read keeps flag, write to alarm clears
    touch(3); #1; chk("R10 other addr", int'(irq), 1);
    wrReg(7, 'h80); #1; chk("R10 write clears", int'(irq), 0);
    // R10 set beats clear in one cycle
    @(negedge clk); tick = 1'b1; hostAddr = 4'd4; hostRd = 1'b1;
    @(negedge clk); tick = 1'b0; hostRd = 1'b0;
    rdReg(9, v); chk("R10 set wins", v, 1);
    // R11 write in tick cycle
    wrReg(8, 'h00);
    setTime(1, 0, 0, 10, 0);
    @(negedge clk); tick = 1'b1; hostAddr = 4'd0; hostWdata = 8'h45; hostWr = 1'b1;
    @(negedge clk); tick = 1'b0; hostWr = 1'b0;
    ms = 45; checkTime("R11 tick dropped");
    doTick(); modelTick(); checkTime("R11 resumes");
    // R3 stop again
    wrReg(8, 'h80); doTick(); checkTime("R3 restopped");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule